// File: doc/BRIEF.md
# DAQ Trigger Frame Qualifier

This block decides whether the acquisition frame opened by a run trigger is to be kept by the data acquisition system. A run trigger opens an acceptance window that lasts a fixed time, 500 µs by default. The first DAQ trigger that comes strictly after the run trigger and inside that window tags the frame. The tag stays high until the next run trigger. A DAQ trigger that arrives too early, too late or with no window open is refused, and a one-cycle error pulse reports it. The DAQ trigger decides only which frame is kept. It has no influence on integration timing, and where it falls inside the window does not matter.

The block also drives a ready-made delay value for a local DAQ-trigger delay generator. The value is the configured run-trigger delay plus an offset of 250 µs, in clock cycles. A user sets the DAQ delay equal to the run delay, and the trigger then lands halfway into the acceptance window. All times are counted in cycles of the block clock (125 MHz by default), so the 500 µs window is 62500 cycles and the 250 µs offset is 31250 cycles.

Top module: `daq_frame_qualifier`

## Requirements
- R1: After reset, `frame_save` and `late_err` are 0 and no acceptance window is open.
- R2: A DAQ trigger sampled k clock edges after the edge that sampled the run trigger, with 1 ≤ k ≤ WIN (WIN = CLK_MHZ × WIN_US cycles), tags the frame: `frame_save` is 1 from the cycle after that edge. `late_err` stays 0.
- R3: `frame_save` stays 1 until a run trigger is sampled. It is 0 in the cycle after that run trigger.
- R4: A DAQ trigger sampled WIN+1 or more edges after the run trigger gives `late_err` = 1 for the following cycle and does not tag the frame.
- R5: A DAQ trigger sampled when no run trigger has been seen since reset gives a `late_err` pulse and no tag.
- R6: A DAQ trigger sampled at the same edge as a run trigger is not after it. It gives a `late_err` pulse and no tag.
- R7: Further DAQ triggers inside the same window after the frame is tagged are ignored: `frame_save` stays 1 and `late_err` stays 0.
- R8: A run trigger that comes while a window is open restarts the count. Acceptance is then measured from the newest run trigger.
- R9: `daq_delay` equals `run_delay` + CLK_MHZ × OFFSET_US. It is one bit wider than `run_delay`, so the sum never wraps.
- R10: `daq_delay` depends only on `run_delay`. Triggers do not change it.
- R11: `late_err` is high only in the cycle right after an edge that sampled a refused DAQ trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all times are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_trig | input | 1 | Run trigger, a one-cycle pulse that opens a window |
| daq_trig | input | 1 | DAQ trigger, a one-cycle pulse asking to keep the frame |
| run_delay | input | DLY_W | Configured run-trigger delay in cycles |
| frame_save | output | 1 | Frame tagged for saving; held until the next run trigger |
| late_err | output | 1 | One-cycle pulse when a DAQ trigger is refused |
| daq_delay | output | DLY_W+1 | Derived DAQ-trigger delay in cycles |

## Verification
The bench opens a window with a run trigger and then sends a DAQ trigger after several gaps. The gaps are zero, one, a value in the middle of the window, the last accepted cycle, the first refused cycle, and a value well past the window. Together they locate both edges of the acceptance range to the exact cycle. Directed cases separate the remaining behaviours. A trigger with no window tells the refusal path apart from a stale count. A retriggered run shows whether the count restarts. A second DAQ trigger after a tag shows that extra triggers are ignored rather than flagged. The delay output is tried at zero, at an ordinary value and at the largest `run_delay`, and also while triggers toggle.

// File: rtl/daq_frame_qualifier.sv
module daq_frame_qualifier #(
  parameter int CLK_MHZ   = 125,
  parameter int WIN_US    = 500,
  parameter int OFFSET_US = 250,
  parameter int DLY_W     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_trig,
  input  logic             daq_trig,
  input  logic [DLY_W-1:0] run_delay,
  output logic             frame_save,
  output logic             late_err,
  output logic [DLY_W:0]   daq_delay
);

  localparam int WIN_CYC = CLK_MHZ * WIN_US;
  localparam int OFF_CYC = CLK_MHZ * OFFSET_US;
  localparam int AGE_W   = $clog2(WIN_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(WIN_CYC);
  localparam logic [DLY_W:0]   OFF_V    = (DLY_W+1)'(OFF_CYC);

  logic             open_q;
  logic             used_q;
  logic             save_q;
  logic             err_q;
  logic [AGE_W-1:0] age_q;

  wire accept = daq_trig && !run_trig && open_q && !used_q;
  wire refuse = daq_trig && (run_trig || !open_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      used_q <= 1'b0;
      save_q <= 1'b0;
      err_q  <= 1'b0;
      age_q  <= '0;
    end else begin
      err_q <= refuse;
      if (run_trig) begin
        open_q <= 1'b1;
        used_q <= 1'b0;
        save_q <= 1'b0;
        age_q  <= AGE_W'(1);
      end else begin
        if (accept) begin
          used_q <= 1'b1;
          save_q <= 1'b1;
        end
        if (open_q) begin
          if (age_q == AGE_LAST) open_q <= 1'b0;
          else                   age_q  <= age_q + AGE_W'(1);
        end
      end
    end
  end

  assign frame_save = save_q;
  assign late_err   = err_q;
  assign daq_delay  = {1'b0, run_delay} + OFF_V;

endmodule

// File: rtl/daq_frame_qualifier_chk.sv
module daq_frame_qualifier_chk #(
  parameter int WIN_CYC = 62500
) (
  input logic clk,
  input logic rst_n,
  input logic run_trig,
  input logic daq_trig,
  input logic frame_save,
  input logic late_err
);

  int age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          age <= 0;
    else if (run_trig)                   age <= 1;
    else if (age != 0 && age <= WIN_CYC) age <= age + 1;
  end

  p_tag_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_save) |-> ($past(daq_trig) && $past(age) >= 1 && $past(age) <= WIN_CYC));

  p_tag_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_save && !run_trig |=> frame_save);

  p_tag_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_trig |=> !frame_save);

  p_outside_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    daq_trig && !run_trig && (age == 0 || age > WIN_CYC) |=> late_err);

  p_same_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_trig && daq_trig |=> late_err && !frame_save);

  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    late_err |-> $past(daq_trig));

endmodule

bind daq_frame_qualifier daq_frame_qualifier_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .run_trig(run_trig),
  .daq_trig(daq_trig),
  .frame_save(frame_save),
  .late_err(late_err)
);

// File: tb/daq_frame_qualifier_bench.sv
module daq_frame_qualifier_bench;

  localparam int CLK_MHZ = 1;
  localparam int WIN_US  = 20;
  localparam int OFF_US  = 10;
  localparam int DLY_W   = 8;
  localparam int WIN     = CLK_MHZ * WIN_US;
  localparam int OFF     = CLK_MHZ * OFF_US;

  localparam int NV = 7;
  localparam int VEC_GAP  [NV] = '{0, 1, 7, WIN - 1, WIN, WIN + 1, WIN + 10};
  localparam int VEC_SAVE [NV] = '{0, 1, 1, 1,       1,   0,       0};
  localparam int VEC_ERR  [NV] = '{1, 0, 0, 0,       0,   1,       1};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run_trig = 1'b0;
  logic             daq_trig = 1'b0;
  logic [DLY_W-1:0] run_delay = '0;
  logic             frame_save;
  logic             late_err;
  logic [DLY_W:0]   daq_delay;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  daq_frame_qualifier #(.CLK_MHZ(CLK_MHZ), .WIN_US(WIN_US), .OFFSET_US(OFF_US), .DLY_W(DLY_W))
    u_daq_frame_qualifier (
      .clk(clk), .rst_n(rst_n), .run_trig(run_trig), .daq_trig(daq_trig),
      .run_delay(run_delay), .frame_save(frame_save), .late_err(late_err),
      .daq_delay(daq_delay));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic r, input logic d);
    run_trig = r;
    daq_trig = d;
    @(posedge clk);
    @(negedge clk);
    run_trig = 1'b0;
    daq_trig = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    check("R1 frame_save after reset", frame_save, 0);
    check("R1 late_err after reset", late_err, 0);
    do_reset();
    check("R1 frame_save idle", frame_save, 0);

    // R5: DAQ trigger with no run trigger since reset
    tick(0, 1);
    check("R5 late_err no window", late_err, 1);
    check("R5 frame_save no window", frame_save, 0);
    tick(0, 0);
    check("R11 late_err one cycle", late_err, 0);

    // R2 R4 R6: table of gaps between run and DAQ trigger
    for (int i = 0; i < NV; i++) begin
      do_reset();
      if (VEC_GAP[i] == 0) tick(1, 1);
      else begin
        tick(1, 0);
        repeat (VEC_GAP[i] - 1) tick(0, 0);
        tick(0, 1);
      end
      check($sformatf("R2/R4/R6 save gap %0d", VEC_GAP[i]), frame_save, VEC_SAVE[i]);
      check($sformatf("R2/R4/R6 err gap %0d", VEC_GAP[i]), late_err, VEC_ERR[i]);
      tick(0, 0);
      check($sformatf("R11 err clears gap %0d", VEC_GAP[i]), late_err, 0);
    end

    // R7: extra DAQ triggers after tag are ignored
    do_reset();
    tick(1, 0);
    repeat (2) tick(0, 0);
    tick(0, 1);
    check("R2 tag", frame_save, 1);
    tick(0, 1);
    check("R7 second daq no err", late_err, 0);
    check("R7 second daq save held", frame_save, 1);
    repeat (5) tick(0, 0);
    check("R3 save held", frame_save, 1);
    tick(1, 0);
    check("R3 save cleared by run", frame_save, 0);

    // R8: retrigger restarts window
    do_reset();
    tick(1, 0);
    repeat (14) tick(0, 0);
    tick(1, 0);
    repeat (14) tick(0, 0);
    tick(0, 1);
    check("R8 tag after restart", frame_save, 1);
    check("R8 no err after restart", late_err, 0);

    // R9 R10: delay output
    run_delay = 8'd0;
    #1 check("R9 delay zero", int'(daq_delay), OFF);
    run_delay = 8'd100;
    #1 check("R9 delay mid", int'(daq_delay), 100 + OFF);
    run_delay = 8'hFF;
    #1 check("R9 delay max no wrap", int'(daq_delay), 255 + OFF);
    tick(1, 1);
    check("R10 delay with triggers", int'(daq_delay), 255 + OFF);
    tick(0, 1);
    check("R10 delay stable", int'(daq_delay), 255 + OFF);

    finish_run();
  end

endmodule